// File: doc/BRIEF.md
# Accumulating ALU Function Unit

This block is one arithmetic/logic unit attached to a shared 16-bit data bus. It holds a single internal result register. In a cycle where the unit is chosen as the destination, it takes the bus value, optionally complements it, and combines it with the register according to the function-select option lines. The result is written back into the register on that clock edge. In a cycle where the unit is chosen as the source, it places the register on its bus output, so a result loaded in one cycle can be read back in any later cycle.

The same option lines that other bus units share select the operation when the unit loads. A two-bit function code picks load, add, exclusive-or, or a logic operation whose AND/OR choice follows the carry-in line. For subtraction, the bus operand is inverted and the carry-in is set to one. Three live feedback outputs describe the value the register currently holds: unsigned carry, signed overflow and zero. The control sequencer can branch on them. There is no separate flag register to read or save.

Top module: `accu_alu_unit`

## Requirements
- R1: After reset the result register is 0, so carry and overflow read 0 and zero reads 1.
- R2: With loadEn high and fnSel=0, the register takes the bus operand. The operand is busIn, or ~busIn when invertOp is 1. carryIn has no effect in this mode.
- R3: With loadEn high and fnSel=1, the register takes the low 16 bits of register + operand + carryIn. flagCarry then shows bit 16 of that sum.
- R4: With fnSel=1, invertOp=1 and carryIn=1, the register becomes register minus busIn (mod 2^16). flagCarry is 1 exactly when register >= busIn as unsigned numbers.
- R5: After an add, flagOvfl is 1 exactly when register and operand had equal sign bits (bit 15) and the sum's bit 15 differs from them.
- R6: With fnSel=2, the register takes register XOR operand.
- R7: With fnSel=3, the register takes register AND operand when carryIn=0, and register OR operand when carryIn=1.
- R8: Any load with fnSel other than 1 clears flagCarry and flagOvfl.
- R9: flagZero is 1 exactly when the register currently holds 0.
- R10: While loadEn is low, the register, flagCarry and flagOvfl keep their values, whatever busIn, fnSel, carryIn and invertOp do.
- R11: While driveEn is high, busOut equals the register and busOe is 1. Otherwise busOut is 0 and busOe is 0. A load and a drive in the same cycle drive the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Unit is destination this cycle |
| driveEn | input | 1 | Unit is source this cycle |
| busIn | input | 16 | Value present on the data bus |
| fnSel | input | 2 | Function select: 0 load, 1 add, 2 xor, 3 and/or |
| carryIn | input | 1 | Adder carry-in; AND/OR choice for code 3 |
| invertOp | input | 1 | Complement the bus operand |
| busOut | output | 16 | Register value toward the bus |
| busOe | output | 1 | Bus output enable |
| flagCarry | output | 1 | Unsigned carry of the held result |
| flagOvfl | output | 1 | Signed overflow of the held result |
| flagZero | output | 1 | Held result is zero |

## Verification
The register, carry and overflow change one clock edge after a cycle with loadEn high. flagZero follows the register with no further delay. busOut and busOe follow driveEn in the same cycle, with no register in the path. The bench applies each operation on a falling edge and lets the rising edge latch it. It then raises driveEn and compares the bus output and all three flags shortly after the next falling edge, against a bench model updated once per load. Hold checks run several idle cycles with changing inputs before the same comparison.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;
  typedef enum logic [1:0] {
    FN_LOAD  = 2'd0,
    FN_ADD   = 2'd1,
    FN_XOR   = 2'd2,
    FN_LOGIC = 2'd3
  } aluFn_e;

  typedef struct packed {
    logic writeEn;
    logic invert;
    logic carry;
    logic selLoad;
    logic selAdd;
    logic selXor;
    logic selAnd;
    logic selOr;
  } aluStrobe_t;
endpackage

// File: rtl/accu_alu_ctrl.sv
module accu_alu_ctrl
  import accu_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [1:0] fnSel,
  input  logic       carryIn,
  input  logic       invertOp,
  output aluStrobe_t strobe
);
  aluFn_e fnCode;
  assign fnCode = aluFn_e'(fnSel);

  always_comb begin
    strobe = '0;
    strobe.writeEn = loadEn;
    strobe.invert  = invertOp;
    strobe.carry   = carryIn & (fnCode == FN_ADD);
    unique case (fnCode)
      FN_LOAD:  strobe.selLoad = 1'b1;
      FN_ADD:   strobe.selAdd  = 1'b1;
      FN_XOR:   strobe.selXor  = 1'b1;
      FN_LOGIC: begin
        strobe.selAnd = ~carryIn;
        strobe.selOr  = carryIn;
      end
      default:  strobe.selLoad = 1'b1;
    endcase
  end

  // R2 R3 R6 R7: exactly one function path selected per load
  p_one_function_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> $countones({strobe.selLoad, strobe.selAdd, strobe.selXor,
                           strobe.selAnd, strobe.selOr}) == 1);
endmodule

// File: rtl/accu_alu_datapath.sv
module accu_alu_datapath
  import accu_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] accOut,
  output logic             carryOut,
  output logic             ovflOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] acc, operand, sum, logicRes, nextAcc;
  logic [WIDTH:0]   carryChain;
  logic             cyReg, ovReg, nextCy, nextOv;

  assign operand = strobe.invert ? ~busIn : busIn;

  assign carryChain[0] = strobe.carry;
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum[i] = acc[i] ^ operand[i] ^ carryChain[i];
      assign carryChain[i+1] = (acc[i] & operand[i]) |
                               (carryChain[i] & (acc[i] ^ operand[i]));
    end
  endgenerate

  always_comb begin
    logicRes = '0;
    if (strobe.selXor) logicRes = acc ^ operand;
    if (strobe.selAnd) logicRes = acc & operand;
    if (strobe.selOr)  logicRes = acc | operand;
  end

  always_comb begin
    nextAcc = logicRes;
    nextCy  = 1'b0;
    nextOv  = 1'b0;
    if (strobe.selLoad) nextAcc = operand;
    if (strobe.selAdd) begin
      nextAcc = sum;
      nextCy  = carryChain[WIDTH];
      nextOv  = (acc[MSB] == operand[MSB]) && (sum[MSB] != acc[MSB]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      cyReg <= 1'b0;
      ovReg <= 1'b0;
    end else if (strobe.writeEn) begin
      acc   <= nextAcc;
      cyReg <= nextCy;
      ovReg <= nextOv;
    end
  end

  assign accOut   = acc;
  assign carryOut = cyReg;
  assign ovflOut  = ovReg;

  // R10: register and flags hold while not loading
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeEn |=> $stable(acc) && $stable(cyReg) && $stable(ovReg));
  // R8: non-add loads clear carry and overflow
  p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn && !strobe.selAdd |=> !cyReg && !ovReg);
  // R2: load copies the operand
  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn && strobe.selLoad |=> acc == $past(operand));
  // R5: overflow only possible with equal operand signs
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn && strobe.selAdd && (acc[MSB] != operand[MSB]) |=> !ovReg);
endmodule

// File: rtl/accu_alu_unit.sv
module accu_alu_unit
  import accu_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             driveEn,
  input  logic [WIDTH-1:0] busIn,
  input  logic [1:0]       fnSel,
  input  logic             carryIn,
  input  logic             invertOp,
  output logic [WIDTH-1:0] busOut,
  output logic             busOe,
  output logic             flagCarry,
  output logic             flagOvfl,
  output logic             flagZero
);
  aluStrobe_t       strobe;
  logic [WIDTH-1:0] accVal;

  accu_alu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .fnSel(fnSel),
    .carryIn(carryIn), .invertOp(invertOp), .strobe(strobe)
  );

  accu_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .accOut(accVal), .carryOut(flagCarry), .ovflOut(flagOvfl)
  );

  assign flagZero = (accVal == '0);
  assign busOut   = driveEn ? accVal : '0;
  assign busOe    = driveEn;

  // R11: bus output is quiet when not the source
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0);
  // R9: zero flag agrees with the driven value
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> flagZero == (busOut == '0));
endmodule

// File: tb/sim_accu_alu_unit.sv
module sim_accu_alu_unit;
  logic clk = 0, rstN = 0, loadEn = 0, driveEn = 0, carryIn = 0, invertOp = 0;
  logic [15:0] busIn = 0;
  logic [1:0]  fnSel = 0;
  logic [15:0] busOut;
  logic busOe, flagCarry, flagOvfl, flagZero;
  int total = 0, bad = 0, cycles = 0;
  logic [15:0] mAcc = 0;
  logic mCy = 0, mOv = 0;

  always #10 clk = ~clk;

  accu_alu_unit u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .driveEn(driveEn), .busIn(busIn),
    .fnSel(fnSel), .carryIn(carryIn), .invertOp(invertOp), .busOut(busOut),
    .busOe(busOe), .flagCarry(flagCarry), .flagOvfl(flagOvfl), .flagZero(flagZero)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    driveEn = 1;
    #1;
    chk(tag, busOut, mAcc);
    chk({tag, "/R11 oe"}, busOe, 1);
    chk({tag, "/carry"}, flagCarry, mCy);
    chk({tag, "/R5 ovfl"}, flagOvfl, mOv);
    chk({tag, "/R9 zero"}, flagZero, mAcc == 0);
    driveEn = 0;
    #1;
    chk("R11 quiet bus", {busOe, busOut}, 0);
  endtask

  task automatic doOp(int fn, bit cin, bit inv, logic [15:0] v);
    logic [15:0] op;
    logic [16:0] s;
    string tag;
    @(negedge clk);
    fnSel = fn[1:0]; carryIn = cin; invertOp = inv; busIn = v; loadEn = 1;
    op = inv ? ~v : v;
    mCy = 0; mOv = 0;
    case (fn)
      0: begin mAcc = op; tag = "R2 load"; end
      1: begin
        s = {1'b0, mAcc} + {1'b0, op} + {16'd0, cin};
        mOv = (mAcc[15] == op[15]) && (s[15] != mAcc[15]);
        mAcc = s[15:0]; mCy = s[16];
        tag = (inv && cin) ? "R4 sub" : "R3 add";
      end
      2: begin mAcc = mAcc ^ op; tag = "R6 xor"; end
      default: begin mAcc = cin ? (mAcc | op) : (mAcc & op); tag = "R7 and/or"; end
    endcase
    if (fn != 1) tag = {tag, "/R8"};
    @(posedge clk);
    @(negedge clk);
    loadEn = 0;
    checkState(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] seed;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkState("R1 reset");
    // Directed corners
    doOp(0, 0, 0, 16'h7FFF);
    doOp(1, 0, 0, 16'h0001);            // R5 signed overflow
    doOp(0, 1, 0, 16'hFFFF);            // R2 carryIn ignored
    doOp(1, 1, 0, 16'h0000);            // R3 carry out, result zero
    doOp(0, 0, 0, 16'h1234);
    doOp(1, 1, 1, 16'h1234);            // R4 equal -> zero, no borrow
    doOp(1, 1, 1, 16'h0001);            // R4 borrow
    doOp(2, 0, 0, 16'h00FF);            // R8 clears flags
    // R10 hold with busy inputs
    doOp(0, 0, 0, 16'hA5C3);
    doOp(1, 0, 0, 16'h8000);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      busIn = 16'(k * 16'h3D1); fnSel = 2'(k); carryIn = k[0]; invertOp = k[1];
    end
    @(negedge clk);
    checkState("R10 hold");
    // Sweep of all functions and options over a value sequence
    seed = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      for (int fn = 0; fn < 4; fn++) begin
        for (int m = 0; m < 4; m++) begin
          seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
          if (fn != 0 && (n % 5) == 0) doOp(0, 0, 0, seed ^ 16'h5A5A);
          doOp(fn, m[0], m[1], (n == 7) ? 16'h8000 : seed);
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule